// File: doc/BRIEF.md
# ROM Header CRC Validator

This block watches a device description ROM image as it streams past, one byte per accepted cycle, with each byte tagged by its index inside the image. While the bytes go by, it collects the fixed header fields and runs two independent checksums. The first is an 8-bit CRC over the eight identifier bytes, which must match the stored identifier checksum. The second is a 32-bit Castagnoli CRC over the data region, which must match the stored data checksum. When the byte flagged as last arrives, the block compares the byte count with the length that the header declares. One cycle later it presents a verdict together with the decoded identifier fields.

The two checks do not carry the same weight. A bad identifier checksum or an inconsistent image size rejects the image. A bad data checksum only raises a warning flag, and the image is still accepted. A ROM revision above 2 raises a separate warning. Another block fetches the bytes and parses the entries that follow the header.

Top module: `rom_hdr_check`

## Requirements
- R1: After reset, `done_o`, `accept_o`, `uid_ok_o`, `data_crc_ok_o`, `size_ok_o` and `rev_unknown_o` are 0, and every field output is 0.
- R2: `uid_ok_o` is 1 exactly when byte 0 equals the CRC-8 over bytes 1 to 8. This CRC starts at 0xFF. Each byte is XORed in, then the value is shifted left 8 times, XORing with 0x07 whenever the bit shifted out was 1. There is no final XOR.
- R3: `data_crc_ok_o` is 1 exactly when `size_ok_o` is 1 and the bytes at indices 9 to 12, read as a little-endian 32-bit value, equal the data CRC. The data CRC is a reflected CRC-32C (polynomial 0x82F63B78 in reflected form), starts from all ones and is inverted at the end. It covers every accepted byte from index 13 up to and including the last byte.
- R4: `size_ok_o` is 1 exactly when two conditions hold. The byte count (index of the last byte plus one) must equal the data length plus 13, where the data length is the low 10 bits of the little-endian 16-bit field at bytes 14 and 15. The byte count must also be at least 22. Upper bits of byte 15 are ignored.
- R5: `accept_o` equals `uid_ok_o AND size_ok_o`. A data CRC mismatch never clears it. All verdict outputs hold their value between `done_o` pulses.
- R6: `rev_unknown_o` is 1 exactly when the revision byte at index 13 is greater than 2.
- R7: The field outputs are assembled little-endian:
  - `uid_o` from bytes 1 to 8
  - `vendor_o` from bytes 16 and 17
  - `model_o` from bytes 18 and 19
  - `model_rev_o` from byte 20
  - `layout_rev_o` from byte 21
  - `data_len_o` is the 10-bit length.
- R8: `done_o` is high for exactly one cycle, and it rises at the clock edge that follows the edge that accepted the byte marked last.
- R9: A `start_i` pulse together with the first byte of the next image may arrive on the edge where the previous verdict is registered. The previous verdict is then still reported intact, and the next image is judged correctly.
- R10: A cycle with `byte_valid_i` low has no effect on any result, whatever `byte_idx_i`, `byte_i` and `byte_last_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears collected state; may coincide with the first byte |
| byte_valid_i | input | 1 | Byte on `byte_i` is accepted this cycle |
| byte_last_i | input | 1 | Accepted byte is the final one of the image |
| byte_idx_i | input | IDX_W | Index of the byte inside the image |
| byte_i | input | 8 | Image byte |
| done_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | Image accepted |
| uid_ok_o | output | 1 | Identifier checksum matches |
| data_crc_ok_o | output | 1 | Data checksum matches (warning only) |
| size_ok_o | output | 1 | Byte count consistent with declared length |
| rev_unknown_o | output | 1 | Revision above the known maximum |
| uid_o | output | 64 | Identifier |
| vendor_o | output | 16 | Vendor identifier |
| model_o | output | 16 | Model identifier |
| model_rev_o | output | 8 | Model revision |
| layout_rev_o | output | 8 | Layout revision byte |
| data_len_o | output | 10 | Declared data length |

## Verification
The two functions that can fall in the same cycle are the registration of one image's verdict and the clearing of the collected state for the next image, together with the capture of that image's first byte. The bench provokes this by sending a second image straight after the last byte of the first one, so that `start_i` and byte 0 land on the very edge that registers the first verdict. The bench then checks two things. The first image's flags and fields must be visible in the following cycle exactly as they would be with idle cycles in between. The second image, built with a corrupted identifier checksum, must receive its own independent verdict.

// File: rtl/rom_hdr_pkg.sv
package rom_hdr_pkg;

   // Byte positions inside the header; the verdict logic depends on them.
   localparam int unsigned UCRC_POS   = 0;
   localparam int unsigned UID_POS    = 1;
   localparam int unsigned UID_BYTES  = 8;
   localparam int unsigned DCRC_POS   = 9;
   localparam int unsigned DCRC_BYTES = 4;
   localparam int unsigned REV_POS    = 13;
   localparam int unsigned LEN_POS    = 14;
   localparam int unsigned VEND_POS   = 16;
   localparam int unsigned MODEL_POS  = 18;
   localparam int unsigned MREV_POS   = 20;
   localparam int unsigned LREV_POS   = 21;
   localparam int unsigned HDR_BYTES  = 22;
   localparam int unsigned DATA_START = 13;
   localparam int unsigned LEN_BITS   = 10;

   typedef struct packed {
      logic [7:0]          uid_crc;
      logic [63:0]         uid;
      logic [31:0]         data_crc;
      logic [7:0]          rom_rev;
      logic [LEN_BITS-1:0] dlen;
      logic [15:0]         vendor;
      logic [15:0]         model;
      logic [7:0]          model_rev;
      logic [7:0]          layout_rev;
   } hdr_t;

endpackage

// File: rtl/crc_engine.sv
module crc_engine #(
   parameter int         W       = 8,
   parameter logic [W-1:0] POLY  = '0,
   parameter logic [W-1:0] INIT  = '0,
   parameter logic [W-1:0] XOROUT = '0,
   parameter bit         REFLECT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic [7:0]   din_i,
   output logic [W-1:0] crc_o
);

   if (W < 8) begin : g_bad_width
      $error("crc_engine: W must be at least 8");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] base;
   logic [W-1:0] nxt;

   always_comb base = clr_i ? INIT : state_q;

   if (REFLECT) begin : g_lsb_first
      always_comb begin
         nxt = base ^ W'(din_i);
         for (int b = 0; b < 8; b++) begin
            nxt = nxt[0] ? ((nxt >> 1) ^ POLY) : (nxt >> 1);
         end
      end
   end else begin : g_msb_first
      always_comb begin
         nxt = base ^ (W'(din_i) << (W - 8));
         for (int b = 0; b < 8; b++) begin
            nxt = nxt[W-1] ? ((nxt << 1) ^ POLY) : (nxt << 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state_q <= INIT;
      else if (en_i)  state_q <= nxt;
      else if (clr_i) state_q <= INIT;
   end

   assign crc_o = state_q ^ XOROUT;

   // R9
   crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !en_i) |=> (state_q == INIT));

   // R10
   crc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !en_i) |=> $stable(state_q));

endmodule

// File: rtl/hdr_capture.sv
module hdr_capture
   import rom_hdr_pkg::*;
#(
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             valid_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [7:0]       data_i,
   output hdr_t             hdr_o
);

   hdr_t hdr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q <= '0;
      end else begin
         if (clr_i) hdr_q <= '0;
         if (valid_i) begin
            if (idx_i == IDX_W'(UCRC_POS)) hdr_q.uid_crc    <= data_i;
            if (idx_i == IDX_W'(REV_POS))  hdr_q.rom_rev    <= data_i;
            if (idx_i == IDX_W'(MREV_POS)) hdr_q.model_rev  <= data_i;
            if (idx_i == IDX_W'(LREV_POS)) hdr_q.layout_rev <= data_i;
            if (idx_i == IDX_W'(LEN_POS))  hdr_q.dlen[7:0]  <= data_i;
            if (idx_i == IDX_W'(LEN_POS + 1))
               hdr_q.dlen[LEN_BITS-1:8] <= data_i[LEN_BITS-9:0];
            for (int k = 0; k < int'(UID_BYTES); k++) begin
               if (idx_i == IDX_W'(UID_POS + k)) hdr_q.uid[8*k +: 8] <= data_i;
            end
            for (int k = 0; k < int'(DCRC_BYTES); k++) begin
               if (idx_i == IDX_W'(DCRC_POS + k)) hdr_q.data_crc[8*k +: 8] <= data_i;
            end
            for (int k = 0; k < 2; k++) begin
               if (idx_i == IDX_W'(VEND_POS + k))  hdr_q.vendor[8*k +: 8] <= data_i;
               if (idx_i == IDX_W'(MODEL_POS + k)) hdr_q.model[8*k +: 8]  <= data_i;
            end
         end
      end
   end

   assign hdr_o = hdr_q;

   // R10
   hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !clr_i) |=> $stable(hdr_q));

   // R9
   clear_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !valid_i) |=> (hdr_q == '0));

endmodule

// File: rtl/hdr_verdict.sv
module hdr_verdict
   import rom_hdr_pkg::*;
#(
   parameter int IDX_W   = 16,
   parameter int REV_MAX = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fin_i,
   input  hdr_t                hdr_i,
   input  logic [7:0]          crc8_i,
   input  logic [31:0]         crc32_i,
   input  logic [IDX_W:0]      count_i,
   output logic                done_o,
   output logic                accept_o,
   output logic                uid_ok_o,
   output logic                data_ok_o,
   output logic                size_ok_o,
   output logic                rev_unk_o,
   output logic [63:0]         uid_o,
   output logic [15:0]         vendor_o,
   output logic [15:0]         model_o,
   output logic [7:0]          model_rev_o,
   output logic [7:0]          layout_rev_o,
   output logic [LEN_BITS-1:0] dlen_o
);

   localparam int CW = IDX_W + 1;

   logic [CW-1:0] want_cnt;
   logic          uid_ok_c, size_ok_c, data_ok_c, rev_c;

   always_comb begin
      want_cnt  = CW'(hdr_i.dlen) + CW'(DATA_START);
      uid_ok_c  = (crc8_i == hdr_i.uid_crc);
      size_ok_c = (count_i == want_cnt) && (count_i >= CW'(HDR_BYTES));
      data_ok_c = (crc32_i == hdr_i.data_crc) && size_ok_c;
      rev_c     = (hdr_i.rom_rev > 8'(REV_MAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o       <= 1'b0;
         accept_o     <= 1'b0;
         uid_ok_o     <= 1'b0;
         data_ok_o    <= 1'b0;
         size_ok_o    <= 1'b0;
         rev_unk_o    <= 1'b0;
         uid_o        <= '0;
         vendor_o     <= '0;
         model_o      <= '0;
         model_rev_o  <= '0;
         layout_rev_o <= '0;
         dlen_o       <= '0;
      end else begin
         done_o <= fin_i;
         if (fin_i) begin
            accept_o     <= uid_ok_c && size_ok_c;
            uid_ok_o     <= uid_ok_c;
            data_ok_o    <= data_ok_c;
            size_ok_o    <= size_ok_c;
            rev_unk_o    <= rev_c;
            uid_o        <= hdr_i.uid;
            vendor_o     <= hdr_i.vendor;
            model_o      <= hdr_i.model;
            model_rev_o  <= hdr_i.model_rev;
            layout_rev_o <= hdr_i.layout_rev;
            dlen_o       <= hdr_i.dlen;
         end
      end
   end

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(accept_o) && $stable(uid_ok_o) && $stable(size_ok_o)
                   && $stable(data_ok_o) && $stable(rev_unk_o)));

   // R3
   crc_needs_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_ok_o |-> size_ok_o);

endmodule

// File: rtl/rom_hdr_check.sv
module rom_hdr_check
   import rom_hdr_pkg::*;
#(
   parameter int IDX_W   = 16,
   parameter int REV_MAX = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             byte_valid_i,
   input  logic             byte_last_i,
   input  logic [IDX_W-1:0] byte_idx_i,
   input  logic [7:0]       byte_i,
   output logic             done_o,
   output logic             accept_o,
   output logic             uid_ok_o,
   output logic             data_crc_ok_o,
   output logic             size_ok_o,
   output logic             rev_unknown_o,
   output logic [63:0]      uid_o,
   output logic [15:0]      vendor_o,
   output logic [15:0]      model_o,
   output logic [7:0]       model_rev_o,
   output logic [7:0]       layout_rev_o,
   output logic [9:0]       data_len_o
);

   localparam int CW = IDX_W + 1;

   if (IDX_W < 11) begin : g_idx_too_narrow
      $error("rom_hdr_check: IDX_W cannot index a full-length image");
   end
   if (REV_MAX < 0 || REV_MAX > 255) begin : g_rev_range
      $error("rom_hdr_check: REV_MAX must fit in one byte");
   end

   logic          uid_en, data_en;
   logic          fin_q;
   logic [CW-1:0] count_q;
   logic [7:0]    crc8;
   logic [31:0]   crc32;
   hdr_t          hdr;

   assign uid_en  = byte_valid_i && (byte_idx_i >= IDX_W'(UID_POS))
                    && (byte_idx_i < IDX_W'(UID_POS + UID_BYTES));
   assign data_en = byte_valid_i && (byte_idx_i >= IDX_W'(DATA_START));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fin_q   <= 1'b0;
         count_q <= '0;
      end else begin
         fin_q <= byte_valid_i && byte_last_i;
         if (byte_valid_i && byte_last_i) count_q <= CW'(byte_idx_i) + CW'(1);
      end
   end

   crc_engine #(
      .W(8), .POLY(8'h07), .INIT(8'hFF), .XOROUT(8'h00), .REFLECT(1'b0)
   ) u_uid_crc (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .en_i(uid_en),
      .din_i(byte_i), .crc_o(crc8)
   );

   crc_engine #(
      .W(32), .POLY(32'h82F6_3B78), .INIT(32'hFFFF_FFFF),
      .XOROUT(32'hFFFF_FFFF), .REFLECT(1'b1)
   ) u_data_crc (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .en_i(data_en),
      .din_i(byte_i), .crc_o(crc32)
   );

   hdr_capture #(.IDX_W(IDX_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .valid_i(byte_valid_i),
      .idx_i(byte_idx_i), .data_i(byte_i), .hdr_o(hdr)
   );

   hdr_verdict #(.IDX_W(IDX_W), .REV_MAX(REV_MAX)) u_verdict (
      .clk(clk), .rst_n(rst_n), .fin_i(fin_q), .hdr_i(hdr),
      .crc8_i(crc8), .crc32_i(crc32), .count_i(count_q),
      .done_o(done_o), .accept_o(accept_o), .uid_ok_o(uid_ok_o),
      .data_ok_o(data_crc_ok_o), .size_ok_o(size_ok_o),
      .rev_unk_o(rev_unknown_o), .uid_o(uid_o), .vendor_o(vendor_o),
      .model_o(model_o), .model_rev_o(model_rev_o),
      .layout_rev_o(layout_rev_o), .dlen_o(data_len_o)
   );

   // R8
   done_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(byte_valid_i && byte_last_i, 2));

endmodule

// File: tb/test_rom_hdr_check.sv
module test_rom_hdr_check;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, valid = 1'b0, last = 1'b0;
   logic [15:0] idx = '0;
   logic [7:0]  data = '0;
   logic        done, accept, uid_ok, data_ok, size_ok, rev_unk;
   logic [63:0] uid;
   logic [15:0] vendor, model;
   logic [7:0]  model_rev, layout_rev;
   logic [9:0]  data_len;

   int total = 0;
   int fails = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   rom_hdr_check i_rom_hdr_check (
      .clk(clk), .rst_n(rst_n), .start_i(start), .byte_valid_i(valid),
      .byte_last_i(last), .byte_idx_i(idx), .byte_i(data),
      .done_o(done), .accept_o(accept), .uid_ok_o(uid_ok),
      .data_crc_ok_o(data_ok), .size_ok_o(size_ok), .rev_unknown_o(rev_unk),
      .uid_o(uid), .vendor_o(vendor), .model_o(model),
      .model_rev_o(model_rev), .layout_rev_o(layout_rev), .data_len_o(data_len)
   );

   typedef struct {
      logic        d0, d1, d2;
      logic        acc, uok, dok, sok, rev;
      logic [63:0] uid;
      logic [15:0] ven, mod;
      logic [7:0]  mrev, lrev;
      logic [9:0]  dlen;
   } snap_t;

   logic [7:0] img [0:1][0:255];
   snap_t s_cur, s_prev;

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic snap_t grab();
      snap_t s;
      s.d0 = 1'b0; s.d2 = 1'b0; s.d1 = done;
      s.acc = accept; s.uok = uid_ok; s.dok = data_ok; s.sok = size_ok; s.rev = rev_unk;
      s.uid = uid; s.ven = vendor; s.mod = model; s.mrev = model_rev;
      s.lrev = layout_rev; s.dlen = data_len;
      return s;
   endfunction

   function automatic logic [7:0] f_crc8(input int sel);
      logic [7:0] c = 8'hFF;
      for (int i = 1; i <= 8; i++) begin
         c ^= img[sel][i];
         for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   function automatic logic [31:0] f_crc32(input int sel, input int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 13; i < 13 + n; i++) begin
         c ^= {24'h0, img[sel][i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'h82F6_3B78) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic build(input int sel, input int len, input int rev, input int seed,
                        input bit bad_uid, input bit bad_data);
      logic [31:0] c32;
      logic [7:0]  c8;
      for (int i = 0; i < 256; i++) img[sel][i] = 8'(i * 37 + seed * 11 + 5);
      img[sel][13] = 8'(rev);
      img[sel][14] = 8'(len);
      img[sel][15] = {6'b101101, 2'(len >> 8)};
      c32 = f_crc32(sel, len);
      if (bad_data) c32 ^= 32'h0000_0100;
      for (int k = 0; k < 4; k++) img[sel][9 + k] = c32[8*k +: 8];
      c8 = f_crc8(sel);
      if (bad_uid) c8 ^= 8'h01;
      img[sel][0] = c8;
   endtask

   task automatic send_image(input int sel, input int n, input int gap,
                             input bit tail, input bit snap_prev);
      logic pre;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (snap_prev && i == 0) pre = done;
         if (snap_prev && i == 1) begin s_prev = grab(); s_prev.d0 = pre; end
         if (snap_prev && i == 2) s_prev.d2 = done;
         start = (i == 0); valid = 1'b1; idx = 16'(i);
         data = img[sel][i]; last = (i == n - 1);
         if (gap > 0 && i < n - 1) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               start = 1'b0; valid = 1'b0; idx = 16'(1 + g);
               data = 8'h5A ^ 8'(g); last = 1'b1;
            end
         end
      end
      if (tail) begin
         @(negedge clk);
         start = 1'b0; valid = 1'b0; last = 1'b0;
         pre = done;
         @(negedge clk);
         s_cur = grab(); s_cur.d0 = pre;
         @(negedge clk);
         s_cur.d2 = done;
      end
   endtask

   task automatic check_img(input snap_t s, input int sel, input bit e_uok, input bit e_dok,
                            input bit e_sok, input bit e_rev, input bit fields, input string tag);
      logic [63:0] e_uid;
      for (int k = 0; k < 8; k++) e_uid[8*k +: 8] = img[sel][1 + k];
      chk({tag, " R8 done low before verdict edge"}, 64'(s.d0), 64'd0);
      chk({tag, " R8 done high one cycle"}, 64'(s.d1), 64'd1);
      chk({tag, " R8 done falls after one cycle"}, 64'(s.d2), 64'd0);
      chk({tag, " R2 uid_ok"}, 64'(s.uok), 64'(e_uok));
      chk({tag, " R3 data_crc_ok"}, 64'(s.dok), 64'(e_dok));
      chk({tag, " R4 size_ok"}, 64'(s.sok), 64'(e_sok));
      chk({tag, " R5 accept"}, 64'(s.acc), 64'(e_uok && e_sok));
      chk({tag, " R6 rev_unknown"}, 64'(s.rev), 64'(e_rev));
      if (fields) begin
         chk({tag, " R7 uid"}, s.uid, e_uid);
         chk({tag, " R7 vendor"}, 64'(s.ven), 64'({img[sel][17], img[sel][16]}));
         chk({tag, " R7 model"}, 64'(s.mod), 64'({img[sel][19], img[sel][18]}));
         chk({tag, " R7 model_rev"}, 64'(s.mrev), 64'(img[sel][20]));
         chk({tag, " R7 layout_rev"}, 64'(s.lrev), 64'(img[sel][21]));
         chk({tag, " R7 data_len"}, 64'(s.dlen), 64'({img[sel][15][1:0], img[sel][14]}));
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 done", 64'(done), 0);
      chk("R1 accept", 64'(accept), 0);
      chk("R1 flags", 64'({uid_ok, data_ok, size_ok, rev_unk}), 0);
      chk("R1 uid", uid, 0);
      chk("R1 other fields", 64'({vendor, model, model_rev, layout_rev, data_len}), 0);
   endtask

   task automatic t_good();
      build(0, 40, 1, 3, 0, 0);
      send_image(0, 53, 0, 1, 0);
      check_img(s_cur, 0, 1, 1, 1, 0, 1, "good");
   endtask

   task automatic t_bad_uid();
      build(0, 30, 0, 7, 1, 0);
      send_image(0, 43, 0, 1, 0);
      check_img(s_cur, 0, 0, 1, 1, 0, 1, "bad uid R2");
   endtask

   task automatic t_bad_data();
      build(0, 25, 2, 9, 0, 1);
      send_image(0, 38, 0, 1, 0);
      check_img(s_cur, 0, 1, 0, 1, 0, 1, "bad data R3 R5");
   endtask

   task automatic t_size();
      build(0, 40, 1, 4, 0, 0);
      send_image(0, 52, 0, 1, 0);
      check_img(s_cur, 0, 1, 0, 0, 0, 1, "one short R4");
      send_image(0, 54, 0, 1, 0);
      check_img(s_cur, 0, 1, 0, 0, 0, 1, "one long R4");
      build(0, 5, 1, 6, 0, 0);
      send_image(0, 18, 0, 1, 0);
      check_img(s_cur, 0, 1, 0, 0, 0, 0, "below header R4");
   endtask

   task automatic t_rev();
      build(0, 22, 3, 2, 0, 0);
      send_image(0, 35, 0, 1, 0);
      check_img(s_cur, 0, 1, 1, 1, 1, 0, "rev 3 R6");
      build(0, 22, 2, 2, 0, 0);
      send_image(0, 35, 0, 1, 0);
      check_img(s_cur, 0, 1, 1, 1, 0, 0, "rev 2 R6");
      build(0, 22, 255, 5, 0, 0);
      send_image(0, 35, 0, 1, 0);
      check_img(s_cur, 0, 1, 1, 1, 1, 0, "rev 255 R6");
   endtask

   task automatic t_gaps();
      build(0, 33, 1, 12, 0, 0);
      send_image(0, 46, 2, 1, 0);
      check_img(s_cur, 0, 1, 1, 1, 0, 1, "idle gaps R10");
   endtask

   task automatic t_back_to_back();
      build(0, 30, 1, 21, 0, 0);
      build(1, 25, 2, 33, 1, 0);
      send_image(0, 43, 0, 0, 0);
      send_image(1, 38, 0, 1, 1);
      check_img(s_prev, 0, 1, 1, 1, 0, 1, "R9 first image");
      check_img(s_cur, 1, 0, 1, 1, 0, 1, "R9 second image");
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         total++; fails++;
         $display("FAIL R8 watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_good();
      t_bad_uid();
      t_bad_data();
      t_size();
      t_rev();
      t_gaps();
      t_back_to_back();
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule